// File: doc/BRIEF.md
# Video controller CPU register port

This block sits between a byte-wide processor bus and the register set of a tile and sprite video controller. The processor sees three byte addresses. Address 0 selects which internal 16-bit register the data bytes go to, and a read of address 0 returns the interrupt status. Addresses 2 and 3 carry the low and the high byte of the selected register.

The high byte acts as the latch. Writing it completes the 16-bit word and commits it to the selected register. For the VRAM data port, that commit becomes one word write to an external video memory. The port holds separate write and read pointers into that memory. Both advance by a step taken from the control register. Reads are served from a prefetched word. Memory accesses go through a small sequencer with a request/acknowledge handshake and one queued command. The sequencer reports that it is busy while any access is still open.

Top module: `vid_reg_port`

## Requirements
- R1: A write to address 0 loads the register index from data bits 4:0. A read of address 0 returns the status byte, and its bit 7 always reads 0. Address 1 reads as 0.
- R2: A high-byte write (address 3) with index 0x00 sets the VRAM write pointer to {high, held low}. With index 0x02 it issues one VRAM word write of {high, held low} at the write pointer, and the pointer then advances.
- R3: Index 0x05 is the control register. Its bits 12:11 pick the pointer step after each data access: 0 gives +1, 1 gives +32, 2 gives +64 and 3 gives +128.
- R4: A high-byte write with index 0x01 sets the read pointer and prefetches that word. With index 0x02, address 2 reads the low byte and address 3 reads the high byte of the prefetched word. Reading address 3 advances the read pointer by the step and prefetches the word at the new pointer. With any other index, addresses 2 and 3 read as 0.
- R5: A low-byte write (address 2) only updates the held byte and starts no VRAM access.
- R6: Status bit 6 is 1 while a VRAM access is open or queued. A command committed during an open access is queued and issued after it, in order. A command that arrives while one is already queued is discarded, but the pointers still advance.
- R7: Event inputs latch into status bits: 0 collision, 1 overflow, 2 raster, 3 attribute-table DMA done, 4 VRAM DMA done, 5 vblank. A status read clears them. An event in the same cycle as the read still latches.
- R8: irq_o is high when any of these pairs is set: collision with control bit 0, overflow with bit 1, raster with bit 2, or vblank with bit 3. The two DMA flags never drive irq_o.
- R9: ctrl_o presents the control register. High-byte writes to any index other than 0x00, 0x01, 0x02 and 0x05 change no state and start no VRAM access.
- R10: vram_req_o stays high, with address, write enable and data held stable, until vram_ack_i is seen. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_cs_i | input | 1 | Bus cycle strobe |
| cpu_wr_i | input | 1 | Write cycle |
| cpu_rd_i | input | 1 | Read cycle |
| cpu_addr_i | input | 2 | Byte address (0 index/status, 2 low, 3 high) |
| cpu_wdata_i | input | 8 | Write byte |
| cpu_rdata_o | output | 8 | Read byte (combinational from address) |
| vram_req_o | output | 1 | VRAM access request |
| vram_we_o | output | 1 | 1 write, 0 read |
| vram_addr_o | output | 16 | VRAM word address |
| vram_wdata_o | output | 16 | VRAM write word |
| vram_ack_i | input | 1 | One-cycle access completion |
| vram_rdata_i | input | 16 | VRAM read word, valid with acknowledge |
| evt_i | input | 6 | Event pulses in status bit order |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | 16 | Control register contents |

## Verification
A wrong pointer or step selection shows up at once as a VRAM word written to, or read from, the wrong address. The bench checks this against its own memory model at computed addresses for every step code. A broken queue shows within one access latency: a word goes missing, a dropped command reaches memory, or the busy bit clears early. A wrong status or enable mapping shows on irq_o and on the status byte in the cycle after the event pulse. The bench sweeps every enable pattern against every flag.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  parameter int unsigned AW    = 16;
  parameter int unsigned DW    = 16;
  parameter int unsigned SELW  = 5;
  parameter int unsigned NFLAG = 6;

  localparam logic [SELW-1:0] SEL_WPTR = 5'h00;
  localparam logic [SELW-1:0] SEL_RPTR = 5'h01;
  localparam logic [SELW-1:0] SEL_DATA = 5'h02;
  localparam logic [SELW-1:0] SEL_CTRL = 5'h05;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } vcmd_t;

  function automatic logic [AW-1:0] step_of(input logic [1:0] code);
    case (code)
      2'd0:    step_of = AW'(1);
      2'd1:    step_of = AW'(32);
      2'd2:    step_of = AW'(64);
      default: step_of = AW'(128);
    endcase
  endfunction
endpackage

// File: rtl/vrp_regs.sv
module vrp_regs
  import vrp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_wr_i,
  input  logic            lo_wr_i,
  input  logic            hi_wr_i,
  input  logic            hi_rd_i,
  input  logic [7:0]      wdata_i,
  output logic [SELW-1:0] sel_o,
  output logic [DW-1:0]   ctrl_o,
  output logic            cmd_valid_o,
  output vcmd_t           cmd_o
);
  logic [SELW-1:0] sel_q;
  logic [7:0]      hold_q;
  logic [AW-1:0]   wptr_q, rptr_q;
  logic [DW-1:0]   ctrl_q;
  logic [DW-1:0]   word;
  logic [AW-1:0]   step;
  logic            data_rd;

  assign word    = {wdata_i, hold_q};
  assign step    = step_of(ctrl_q[12:11]);
  assign data_rd = hi_rd_i && (sel_q == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      hold_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (sel_wr_i) sel_q <= wdata_i[SELW-1:0];
      if (lo_wr_i)  hold_q <= wdata_i;
      if (hi_wr_i) begin
        case (sel_q)
          SEL_WPTR: wptr_q <= word;
          SEL_RPTR: rptr_q <= word;
          SEL_DATA: wptr_q <= wptr_q + step;
          SEL_CTRL: ctrl_q <= word;
          default: ;
        endcase
      end else if (data_rd) begin
        rptr_q <= rptr_q + step;
      end
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_o       = '0;
    if (hi_wr_i) begin
      if (sel_q == SEL_RPTR) begin
        cmd_valid_o = 1'b1;
        cmd_o.addr  = word;
      end else if (sel_q == SEL_DATA) begin
        cmd_valid_o = 1'b1;
        cmd_o.we    = 1'b1;
        cmd_o.addr  = wptr_q;
        cmd_o.data  = word;
      end
    end else if (data_rd) begin
      cmd_valid_o = 1'b1;
      cmd_o.addr  = rptr_q + step;
    end
  end

  assign sel_o  = sel_q;
  assign ctrl_o = ctrl_q;

  // R9: a commit to an unused index leaves the control register alone
  p_unused_ctrl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr_i && sel_q != SEL_CTRL) |=> $stable(ctrl_o));
endmodule

// File: rtl/vrp_seq.sv
module vrp_seq
  import vrp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  vcmd_t         cmd_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic [DW-1:0] rbuf_o
);
  logic          act_q, pend_v_q;
  vcmd_t         cur_q, pend_q;
  logic [DW-1:0] rbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      pend_v_q <= 1'b0;
      cur_q    <= '0;
      pend_q   <= '0;
      rbuf_q   <= '0;
    end else begin
      if (act_q && ack_i) begin
        if (!cur_q.we) rbuf_q <= rdata_i;
        if (pend_v_q) begin
          cur_q <= pend_q;
          if (cmd_valid_i) pend_q <= cmd_i;
          else             pend_v_q <= 1'b0;
        end else if (cmd_valid_i) begin
          cur_q <= cmd_i;
        end else begin
          act_q <= 1'b0;
        end
      end else if (!act_q) begin
        if (cmd_valid_i) begin
          act_q <= 1'b1;
          cur_q <= cmd_i;
        end
      end else if (cmd_valid_i && !pend_v_q) begin
        pend_q   <= cmd_i;
        pend_v_q <= 1'b1;
      end
    end
  end

  assign req_o   = act_q;
  assign we_o    = cur_q.we;
  assign addr_o  = cur_q.addr;
  assign wdata_o = cur_q.data;
  assign busy_o  = act_q | pend_v_q;
  assign rbuf_o  = rbuf_q;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  p_queue_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && pend_v_q) |=> req_o);
endmodule

// File: rtl/vrp_status.sv
module vrp_status
  import vrp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             clr_i,
  input  logic             busy_i,
  input  logic [3:0]       en_i,
  output logic [7:0]       stat_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (clr_i ? '0 : flag_q) | evt_i;
  end

  assign stat_o = {1'b0, busy_i, flag_q};
  // DMA-done flags (bits 3, 4) have no enable here
  assign irq_o  = (flag_q[0] & en_i[0]) | (flag_q[1] & en_i[1]) |
                  (flag_q[2] & en_i[2]) | (flag_q[5] & en_i[3]);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> (stat_o[5:0] == '0));

  p_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_o[5:0] & $past(evt_i)) == $past(evt_i)));

  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_o[0] | stat_o[1] | stat_o[2] | stat_o[5]));
endmodule

// File: rtl/vid_reg_port.sv
module vid_reg_port
  import vrp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_cs_i,
  input  logic             cpu_wr_i,
  input  logic             cpu_rd_i,
  input  logic [1:0]       cpu_addr_i,
  input  logic [7:0]       cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o,
  output logic             vram_req_o,
  output logic             vram_we_o,
  output logic [AW-1:0]    vram_addr_o,
  output logic [DW-1:0]    vram_wdata_o,
  input  logic             vram_ack_i,
  input  logic [DW-1:0]    vram_rdata_i,
  input  logic [NFLAG-1:0] evt_i,
  output logic             irq_o,
  output logic [DW-1:0]    ctrl_o
);
  logic            wr, rd, sel_wr, lo_wr, hi_wr, hi_rd, stat_rd;
  logic [SELW-1:0] sel;
  logic            cmd_valid, busy;
  vcmd_t           cmd;
  logic [DW-1:0]   rbuf;
  logic [7:0]      stat;

  assign wr      = cpu_cs_i & cpu_wr_i;
  assign rd      = cpu_cs_i & cpu_rd_i & ~cpu_wr_i;
  assign sel_wr  = wr && cpu_addr_i == 2'd0;
  assign lo_wr   = wr && cpu_addr_i == 2'd2;
  assign hi_wr   = wr && cpu_addr_i == 2'd3;
  assign stat_rd = rd && cpu_addr_i == 2'd0;
  assign hi_rd   = rd && cpu_addr_i == 2'd3;

  vrp_regs u_regs (
    .clk_i, .rst_ni,
    .sel_wr_i(sel_wr), .lo_wr_i(lo_wr), .hi_wr_i(hi_wr), .hi_rd_i(hi_rd),
    .wdata_i(cpu_wdata_i), .sel_o(sel), .ctrl_o(ctrl_o),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd)
  );

  vrp_seq u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .ack_i(vram_ack_i), .rdata_i(vram_rdata_i),
    .req_o(vram_req_o), .we_o(vram_we_o), .addr_o(vram_addr_o),
    .wdata_o(vram_wdata_o), .busy_o(busy), .rbuf_o(rbuf)
  );

  vrp_status u_stat (
    .clk_i, .rst_ni,
    .evt_i(evt_i), .clr_i(stat_rd), .busy_i(busy), .en_i(ctrl_o[3:0]),
    .stat_o(stat), .irq_o(irq_o)
  );

  always_comb begin
    case (cpu_addr_i)
      2'd0:    cpu_rdata_o = stat;
      2'd2:    cpu_rdata_o = (sel == SEL_DATA) ? rbuf[7:0]  : 8'h00;
      2'd3:    cpu_rdata_o = (sel == SEL_DATA) ? rbuf[15:8] : 8'h00;
      default: cpu_rdata_o = 8'h00;
    endcase
  end

  p_low_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr && !vram_req_o) |=> !vram_req_o);

  p_busy_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_req_o |-> stat[6]);
endmodule

// File: tb/vid_reg_port_tb.sv
module vid_reg_port_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        req, we, ack = 1'b0, irq;
  logic [15:0] vaddr, vwdata, vrdata = 16'h0, ctrl;
  logic [5:0]  evt = 6'h0;

  logic [15:0] mem [0:1023];
  int          cnt = 0;
  int          nwr = 0;
  int          nchk = 0, nerr = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  vid_reg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_cs_i(cs), .cpu_wr_i(wr), .cpu_rd_i(rd), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .vram_req_o(req), .vram_we_o(we), .vram_addr_o(vaddr), .vram_wdata_o(vwdata),
    .vram_ack_i(ack), .vram_rdata_i(vrdata),
    .evt_i(evt), .irq_o(irq), .ctrl_o(ctrl)
  );

  // VRAM model: fixed latency, one-cycle acknowledge
  always @(posedge clk) begin
    ack <= 1'b0;
    if (!req) cnt <= 0;
    else if (!ack) begin
      if (cnt == LAT - 1) begin
        cnt <= 0;
        ack <= 1'b1;
        if (we) begin
          mem[vaddr[9:0]] <= vwdata;
          nwr <= nwr + 1;
        end
        vrdata <= mem[vaddr[9:0]];
      end else cnt <= cnt + 1;
    end
  end

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 3 + 16'h5000);
  endfunction

  function automatic int step(input int m);
    case (m)
      0: return 1;
      1: return 32;
      2: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // each bus task starts just after a falling edge and spans one rising edge
  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    cs = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    cs = 1; rd = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic set_reg(input logic [4:0] idx, input logic [15:0] v);
    bwr(2'd0, {3'b0, idx});
    bwr(2'd2, v[7:0]);
    bwr(2'd3, v[15:8]);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      brd(2'd0, s);
      if (!s[6]) return;
    end
    chk("R6 busy never cleared", 32'd1, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int          base, c0;
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    brd(2'd0, b);
    chk("R1 status after reset", b, 8'h00);
    chk("R8 irq after reset", irq, 0);
    chk("R10 no request after reset", req, 0);
    chk("R9 ctrl after reset", ctrl, 16'h0000);
    brd(2'd1, b);
    chk("R1 address 1 reads zero", b, 8'h00);

    // R2 R3: write pointer with every step code
    for (int m = 0; m < 4; m++) begin
      base = m * 8;
      set_reg(5'h05, 16'(m << 11));
      chk("R3 ctrl_o", ctrl, 16'(m << 11));
      set_reg(5'h00, 16'(base));
      bwr(2'd0, 8'h02);
      for (int k = 0; k < 4; k++) begin
        w = 16'hA000 + 16'(m * 16 + k);
        bwr(2'd2, w[7:0]);
        bwr(2'd3, w[15:8]);
        wait_idle();
      end
      for (int k = 0; k < 4; k++)
        chk($sformatf("R2 R3 write m=%0d k=%0d", m, k),
            mem[base + k * step(m)], 16'hA000 + 16'(m * 16 + k));
    end

    // R6: queue one, drop the third
    set_reg(5'h05, 16'h0000);
    set_reg(5'h00, 16'h0200);
    bwr(2'd0, 8'h02);
    bwr(2'd2, 8'h11); bwr(2'd3, 8'hB1);
    bwr(2'd2, 8'h22); bwr(2'd3, 8'hB2);
    bwr(2'd2, 8'h33); bwr(2'd3, 8'hB3);
    brd(2'd0, b);
    chk("R6 busy bit while open", b[6], 1);
    chk("R1 status bit 7", b[7], 0);
    wait_idle();
    chk("R6 first word", mem[512], 16'hB111);
    chk("R6 queued word", mem[513], 16'hB222);
    chk("R6 dropped word", mem[514], init_val(514));
    bwr(2'd2, 8'h44); bwr(2'd3, 8'hB4);
    wait_idle();
    chk("R6 pointer advanced past dropped", mem[515], 16'hB444);

    // R5: low byte alone
    c0 = nwr;
    bwr(2'd2, 8'h99);
    repeat (10) @(negedge clk);
    chk("R5 no access on low write", nwr, c0);
    brd(2'd0, b);
    chk("R5 not busy", b[6], 0);

    // R9: unused indices
    c0 = nwr;
    set_reg(5'h05, 16'h0800);
    set_reg(5'h03, 16'h1234);
    set_reg(5'h04, 16'h5678);
    set_reg(5'h1F, 16'h9ABC);
    chk("R9 ctrl unchanged", ctrl, 16'h0800);
    repeat (8) @(negedge clk);
    chk("R9 no access", nwr, c0);
    bwr(2'd0, 8'h02);
    bwr(2'd2, 8'h55); bwr(2'd3, 8'hB5);
    wait_idle();
    chk("R9 write pointer untouched", mem[516], 16'hB555);

    // R4: read pointer with every step code
    for (int m = 0; m < 4; m++) begin
      base = 600 + m * 2;
      set_reg(5'h05, 16'(m << 11));
      set_reg(5'h01, 16'(base));
      wait_idle();
      brd(2'd2, b);
      chk("R4 other index reads zero", b, 8'h00);
      bwr(2'd0, 8'h02);
      for (int k = 0; k < 3; k++) begin
        w = mem[base + k * step(m)];
        brd(2'd2, b);
        chk($sformatf("R4 low m=%0d k=%0d", m, k), b, w[7:0]);
        brd(2'd3, b);
        chk($sformatf("R4 high m=%0d k=%0d", m, k), b, w[15:8]);
        wait_idle();
      end
    end

    // R7 R8: every enable pattern against every flag
    for (int e = 0; e < 16; e++) begin
      set_reg(5'h05, 16'(e));
      for (int f = 0; f < 6; f++) begin
        bit exp_irq;
        case (f)
          0: exp_irq = e[0];
          1: exp_irq = e[1];
          2: exp_irq = e[2];
          5: exp_irq = e[3];
          default: exp_irq = 1'b0;
        endcase
        evt = 6'(1 << f);
        @(negedge clk);
        evt = 6'h0;
        #1;
        chk($sformatf("R8 irq e=%0d f=%0d", e, f), irq, exp_irq);
        brd(2'd0, b);
        chk($sformatf("R7 flag e=%0d f=%0d", e, f), b, 8'(1 << f));
        brd(2'd0, b);
        chk("R7 cleared by read", b, 8'h00);
        chk("R8 irq after clear", irq, 0);
      end
    end

    // R7: event during the clearing read still latches
    evt = 6'h01;
    @(negedge clk);
    evt = 6'h20;
    brd(2'd0, b);
    chk("R7 first read", b, 8'h01);
    brd(2'd0, b);
    chk("R7 same-cycle event kept", b, 8'h20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule